// File: doc/BRIEF.md
# Multi-Issue Operation Scheduler Window

This block is the central holding buffer between an instruction decoder and a set of execution units. Decoded micro-operations arrive in groups of up to four per clock. Each carries an execution class and an initial operand-ready flag. They are written in program order into a 24-slot circular window. For each of six execution classes, the window picks the oldest entry that is ready and has not yet been sent. It sends that entry to the class's own issue port, so up to six entries leave per clock, out of order with respect to one another.

An issued entry keeps its slot until an execution unit reports it finished, by slot index, on one of the completion ports. Finished entries leave in program order: up to four per clock, taken from the head of the window. Operand readiness is not tracked inside the block. An entry either arrives ready, or is made ready later through a single wake port addressed by slot. A flush empties the window in one clock.

The six class codes are: 0 memory load, 1 memory store, 2 complex register operation, 3 simple register operation, 4 floating-point operation, 5 branch-condition evaluation. Slot indices run from 0 to 23. Lane and port fields are packed with lane 0 in the least significant bits.

Top module: `opsched_window`

## Requirements
- R1: The window never holds more than 24 entries. When the number of valid lanes in an allocation group exceeds the free slots, `stall` is high in that cycle and no lane of the group is written.
- R2: The valid lanes of an accepted group take consecutive slots starting at the tail, lane 0 first, with invalid lanes skipped. Slot 23 is followed by slot 0.
- R3: In each cycle, each of the six class ports (bit c of `issue_valid` carries class code c) sends at most one entry, and that entry's class matches the port. Different ports may send in the same cycle.
- R4: Among entries of one class that are ready and not yet sent, the one nearest the head (oldest) is sent first.
- R5: An entry written at clock edge t appears on an issue port no earlier than after edge t+1, because `issue_valid`/`issue_idx` are registered.
- R6: An entry is sent at most once. It stays in the window after issue until it is reported finished.
- R7: An entry written with its ready flag low is not sent until a wake for its slot. A wake aimed at an empty slot has no effect.
- R8: A completion report marks a slot finished only if that slot holds an entry that has already been issued; other reports are ignored. `retire_valid` is a run of low-order ones, one bit for each entry leaving. Its lanes carry, in order, the longest run of finished entries starting at the head, capped at four.
- R9: Entries finished at edge t show on the retire outputs after edge t+1, and their slots are freed at that same edge.
- R10: A flush empties the window and resets the head and tail to slot 0. An allocation in the same cycle is dropped. Issue and retire outputs are zero after the flush edge.
- R11: `stall` is combinational. It uses the occupancy at the start of the cycle, so slots freed by retirement in that same cycle do not count as free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | ALLOC_W | Per-lane valid of the allocation group |
| alloc_class | input | ALLOC_W*3 | Per-lane execution class code |
| alloc_ready | input | ALLOC_W | Per-lane initial operand-ready flag |
| wake_valid | input | 1 | Set the ready flag of one slot |
| wake_idx | input | IDX_W | Slot addressed by the wake |
| done_valid | input | CMP_W | Per-port completion report valid |
| done_idx | input | CMP_W*IDX_W | Per-port slot index being reported finished |
| flush | input | 1 | Empty the window |
| stall | output | 1 | Allocation group refused this cycle |
| issue_valid | output | 6 | Per-class issue strobe |
| issue_idx | output | 6*IDX_W | Per-class slot index being issued |
| retire_valid | output | RET_W | Retire strobes, low lanes first |
| retire_idx | output | RET_W*IDX_W | Per-lane retired slot index |

## Verification
The hardest state to reach from the ports is a full window whose head entry finishes in the same cycle that a new group arrives. That is the only case that tells a stall based on start-of-cycle occupancy apart from one that counts same-cycle retirement. A related hard case is a long run of finished entries straddling the wrap from slot 23 to slot 0. The bench reaches both with a phase of near-continuous four-lane allocation and rare readiness and completion. That phase keeps the window pinned at 24 while entries trickle out through the head. The bench runs it alongside a cycle-level queue model that predicts every stall, issue and retire lane. Directed openings before the random phases pin down the one-cycle latencies, age order, wake gating and flush-with-allocation.

// File: rtl/opsched_pkg.sv
package opsched_pkg;

  localparam int NCLASS = 6;
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_LOAD   = 3'd0,
    CLS_STORE  = 3'd1,
    CLS_CPLX   = 3'd2,
    CLS_SIMPLE = 3'd3,
    CLS_FP     = 3'd4,
    CLS_BRANCH = 3'd5
  } op_class_e;

endpackage

// File: rtl/opsched_alloc.sv
// Slot assignment for one allocation group: compacts valid lanes onto
// consecutive slots from the tail and decides all-or-nothing acceptance.
module opsched_alloc #(
  parameter int DEPTH = 24,
  parameter int LANES = 4,
  parameter int IDX_W = 5,
  parameter int CNT_W = 5
) (
  input  logic [LANES-1:0] lane_v,
  input  logic [IDX_W-1:0] tail,
  input  logic [CNT_W-1:0] occ,
  output logic             stall,
  output logic [IDX_W-1:0] slot [LANES],
  output logic [CNT_W-1:0] n_take,
  output logic [IDX_W-1:0] tail_next
);

  always_comb begin
    int off;
    int t;
    off = 0;
    for (int k = 0; k < LANES; k++) begin
      int s;
      s = int'(tail) + off;
      if (s >= DEPTH) s = s - DEPTH;
      slot[k] = IDX_W'(s);
      if (lane_v[k]) off = off + 1;
    end
    stall  = (off > (DEPTH - int'(occ)));
    n_take = stall ? '0 : CNT_W'(off);
    t = int'(tail) + (stall ? 0 : off);
    if (t >= DEPTH) t = t - DEPTH;
    tail_next = IDX_W'(t);
  end

endmodule

// File: rtl/opsched_pick.sv
// Oldest-first selector for one execution class, scanning from the head.
module opsched_pick #(
  parameter int DEPTH  = 24,
  parameter int IDX_W  = 5,
  parameter int CLS_W  = 3,
  parameter int CLS_ID = 0
) (
  input  logic [DEPTH-1:0] cand,
  input  logic [CLS_W-1:0] cls [DEPTH],
  input  logic [IDX_W-1:0] head,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int s;
      s = int'(head) + i;
      if (s >= DEPTH) s = s - DEPTH;
      if (!hit && cand[IDX_W'(s)] && (cls[IDX_W'(s)] == CLS_W'(CLS_ID))) begin
        hit = 1'b1;
        idx = IDX_W'(s);
      end
    end
  end

endmodule

// File: rtl/opsched_retire.sv
// In-order retirement: longest run of finished slots from the head.
module opsched_retire #(
  parameter int DEPTH = 24,
  parameter int RET_W = 4,
  parameter int IDX_W = 5,
  parameter int CNT_W = 5
) (
  input  logic [DEPTH-1:0] fin,
  input  logic [IDX_W-1:0] head,
  output logic [RET_W-1:0] mask,
  output logic [IDX_W-1:0] slot [RET_W],
  output logic [CNT_W-1:0] n_ret
);

  always_comb begin
    logic run;
    int   n;
    run  = 1'b1;
    n    = 0;
    mask = '0;
    for (int k = 0; k < RET_W; k++) begin
      int s;
      s = int'(head) + k;
      if (s >= DEPTH) s = s - DEPTH;
      slot[k] = IDX_W'(s);
      if (run && fin[IDX_W'(s)]) begin
        mask[k] = 1'b1;
        n = n + 1;
      end else begin
        run = 1'b0;
      end
    end
    n_ret = CNT_W'(n);
  end

endmodule

// File: rtl/opsched_window.sv
module opsched_window #(
  parameter int DEPTH   = 24,
  parameter int ALLOC_W = 4,
  parameter int RET_W   = 4,
  parameter int CMP_W   = opsched_pkg::NCLASS,
  parameter int IDX_W   = $clog2(DEPTH)
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [ALLOC_W-1:0]                     alloc_valid,
  input  logic [ALLOC_W*opsched_pkg::CLS_W-1:0]  alloc_class,
  input  logic [ALLOC_W-1:0]                     alloc_ready,
  input  logic                                   wake_valid,
  input  logic [IDX_W-1:0]                       wake_idx,
  input  logic [CMP_W-1:0]                       done_valid,
  input  logic [CMP_W*IDX_W-1:0]                 done_idx,
  input  logic                                   flush,
  output logic                                   stall,
  output logic [opsched_pkg::NCLASS-1:0]         issue_valid,
  output logic [opsched_pkg::NCLASS*IDX_W-1:0]   issue_idx,
  output logic [RET_W-1:0]                       retire_valid,
  output logic [RET_W*IDX_W-1:0]                 retire_idx
);

  localparam int NCLASS = opsched_pkg::NCLASS;
  localparam int CLS_W  = opsched_pkg::CLS_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // per-slot state
  logic [DEPTH-1:0] v_q, rdy_q, iss_q, fin_q;
  logic [CLS_W-1:0] cls_q [DEPTH];
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] occ_q;

  // allocation
  logic [IDX_W-1:0] a_slot [ALLOC_W];
  logic [CNT_W-1:0] n_take;
  logic [IDX_W-1:0] tail_nxt;

  opsched_alloc #(
    .DEPTH(DEPTH), .LANES(ALLOC_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_alloc (
    .lane_v    (alloc_valid),
    .tail      (tail_q),
    .occ       (occ_q),
    .stall     (stall),
    .slot      (a_slot),
    .n_take    (n_take),
    .tail_next (tail_nxt)
  );

  // issue selection, one picker per class
  logic [DEPTH-1:0]  cand;
  logic [NCLASS-1:0] pk_hit;
  logic [IDX_W-1:0]  pk_idx [NCLASS];

  assign cand = v_q & rdy_q & ~iss_q;

  for (genvar c = 0; c < NCLASS; c++) begin : g_pick
    opsched_pick #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .CLS_W(CLS_W), .CLS_ID(c)
    ) u_pick (
      .cand (cand),
      .cls  (cls_q),
      .head (head_q),
      .hit  (pk_hit[c]),
      .idx  (pk_idx[c])
    );
  end

  // retirement
  logic [RET_W-1:0] r_mask;
  logic [IDX_W-1:0] r_slot [RET_W];
  logic [CNT_W-1:0] n_ret;
  logic [IDX_W-1:0] head_nxt;

  opsched_retire #(
    .DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ret (
    .fin   (v_q & fin_q),
    .head  (head_q),
    .mask  (r_mask),
    .slot  (r_slot),
    .n_ret (n_ret)
  );

  always_comb begin
    int h;
    h = int'(head_q) + int'(n_ret);
    if (h >= DEPTH) h = h - DEPTH;
    head_nxt = IDX_W'(h);
  end

  // class storage: written only at allocation, no reset needed
  always_ff @(posedge clk) begin
    if (!flush && !stall) begin
      for (int k = 0; k < ALLOC_W; k++) begin
        if (alloc_valid[k]) cls_q[a_slot[k]] <= alloc_class[k*CLS_W +: CLS_W];
      end
    end
  end

  // control state and registered outputs
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      v_q          <= '0;
      rdy_q        <= '0;
      iss_q        <= '0;
      fin_q        <= '0;
      head_q       <= '0;
      tail_q       <= '0;
      occ_q        <= '0;
      issue_valid  <= '0;
      issue_idx    <= '0;
      retire_valid <= '0;
      retire_idx   <= '0;
    end else begin
      if (wake_valid && (int'(wake_idx) < DEPTH) && v_q[wake_idx])
        rdy_q[wake_idx] <= 1'b1;

      for (int p = 0; p < CMP_W; p++) begin
        if (done_valid[p] && (int'(done_idx[p*IDX_W +: IDX_W]) < DEPTH) &&
            v_q[done_idx[p*IDX_W +: IDX_W]] && iss_q[done_idx[p*IDX_W +: IDX_W]])
          fin_q[done_idx[p*IDX_W +: IDX_W]] <= 1'b1;
      end

      for (int c = 0; c < NCLASS; c++) begin
        if (pk_hit[c]) iss_q[pk_idx[c]] <= 1'b1;
      end

      for (int k = 0; k < RET_W; k++) begin
        if (r_mask[k]) begin
          v_q[r_slot[k]]   <= 1'b0;
          rdy_q[r_slot[k]] <= 1'b0;
          iss_q[r_slot[k]] <= 1'b0;
          fin_q[r_slot[k]] <= 1'b0;
        end
      end

      if (!stall) begin
        for (int k = 0; k < ALLOC_W; k++) begin
          if (alloc_valid[k]) begin
            v_q[a_slot[k]]   <= 1'b1;
            rdy_q[a_slot[k]] <= alloc_ready[k];
            iss_q[a_slot[k]] <= 1'b0;
            fin_q[a_slot[k]] <= 1'b0;
          end
        end
      end

      head_q <= head_nxt;
      tail_q <= tail_nxt;
      occ_q  <= occ_q + n_take - n_ret;

      issue_valid <= pk_hit;
      for (int c = 0; c < NCLASS; c++) issue_idx[c*IDX_W +: IDX_W] <= pk_idx[c];
      retire_valid <= r_mask;
      for (int k = 0; k < RET_W; k++) retire_idx[k*IDX_W +: IDX_W] <= r_slot[k];
    end
  end

endmodule

// File: rtl/opsched_chk.sv
module opsched_chk #(
  parameter int DEPTH  = 24,
  parameter int RET_W  = 4,
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 5,
  parameter int NCLASS = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    flush,
  input logic                    stall,
  input logic [CNT_W-1:0]        occ,
  input logic [DEPTH-1:0]        v_q,
  input logic [NCLASS-1:0]       issue_valid,
  input logic [NCLASS*IDX_W-1:0] issue_idx,
  input logic [RET_W-1:0]        retire_valid
);

  // R1
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> (occ <= $past(occ)));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occ == '0 && issue_valid == '0 && retire_valid == '0));

  // R8
  retire_run_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_valid & (retire_valid + RET_W'(1))) == '0);

  for (genvar c = 0; c < NCLASS; c++) begin : g_live
    // R6
    issue_live_chk: assert property (@(posedge clk) disable iff (rst)
      issue_valid[c] |-> v_q[issue_idx[c*IDX_W +: IDX_W]]);
    for (genvar d = c + 1; d < NCLASS; d++) begin : g_pair
      // R3
      issue_distinct_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_valid[c] && issue_valid[d]) |->
          (issue_idx[c*IDX_W +: IDX_W] != issue_idx[d*IDX_W +: IDX_W]));
    end
  end

endmodule

bind opsched_window opsched_chk #(
  .DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .NCLASS(NCLASS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flush        (flush),
  .stall        (stall),
  .occ          (occ_q),
  .v_q          (v_q),
  .issue_valid  (issue_valid),
  .issue_idx    (issue_idx),
  .retire_valid (retire_valid)
);

// File: tb/sim_opsched_window.sv
`timescale 1ns/1ps
module sim_opsched_window;

  localparam int D  = 24;
  localparam int AW = 4;
  localparam int RW = 4;
  localparam int NC = 6;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0]    a_v;
  logic [AW*3-1:0]  a_cls;
  logic [AW-1:0]    a_rdy;
  logic             w_v;
  logic [IW-1:0]    w_idx;
  logic [NC-1:0]    c_v;
  logic [NC*IW-1:0] c_idx;
  logic             fl;
  logic             stall;
  logic [NC-1:0]    issue_valid;
  logic [NC*IW-1:0] issue_idx;
  logic [RW-1:0]    retire_valid;
  logic [RW*IW-1:0] retire_idx;

  opsched_window u0 (
    .clk(clk), .rst(rst),
    .alloc_valid(a_v), .alloc_class(a_cls), .alloc_ready(a_rdy),
    .wake_valid(w_v), .wake_idx(w_idx),
    .done_valid(c_v), .done_idx(c_idx), .flush(fl),
    .stall(stall), .issue_valid(issue_valid), .issue_idx(issue_idx),
    .retire_valid(retire_valid), .retire_idx(retire_idx)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  // reference queue model
  bit mv[D], mr[D], mi[D], md[D];
  int mc[D];
  int mh = 0, mt = 0, mo = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    a_v = '0; a_cls = '0; a_rdy = '0; w_v = 0; w_idx = '0;
    c_v = '0; c_idx = '0; fl = 0;
  endtask

  task automatic put(int lane, int cls, bit rdy);
    a_v[lane] = 1'b1;
    a_cls[lane*3 +: 3] = 3'(cls);
    a_rdy[lane] = rdy;
  endtask

  // apply current inputs for one clock, advance model, compare outputs
  task automatic tick();
    int na, nr;
    bit st;
    bit ev[NC];
    int ei[NC];
    int eri[RW];
    logic [NC-1:0] evp;
    logic [RW-1:0] erp;
    #1;
    na = $countones(a_v);
    st = (na > D - mo);
    nr = 0;
    while (nr < RW && nr < mo && md[(mh + nr) % D]) begin
      eri[nr] = (mh + nr) % D;
      nr++;
    end
    if (st && nr > 0) chk(stall === st, "R11 stall", int'(stall), int'(st));
    else              chk(stall === st, "R1 stall", int'(stall), int'(st));
    if (fl) begin
      for (int s = 0; s < D; s++) begin mv[s] = 0; mr[s] = 0; mi[s] = 0; md[s] = 0; end
      mh = 0; mt = 0; mo = 0; nr = 0;
      for (int c = 0; c < NC; c++) ev[c] = 0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        ev[c] = 0; ei[c] = 0;
        for (int i = 0; i < mo; i++) begin
          int s;
          s = (mh + i) % D;
          if (!ev[c] && mv[s] && mr[s] && !mi[s] && mc[s] == c) begin ev[c] = 1; ei[c] = s; end
        end
      end
      if (w_v && int'(w_idx) < D && mv[w_idx]) mr[w_idx] = 1;
      for (int p = 0; p < NC; p++) begin
        if (c_v[p]) begin
          int s;
          s = int'(c_idx[p*IW +: IW]);
          if (s < D && mv[s] && mi[s]) md[s] = 1;
        end
      end
      for (int c = 0; c < NC; c++) if (ev[c]) mi[ei[c]] = 1;
      for (int k = 0; k < nr; k++) begin
        mv[eri[k]] = 0; mr[eri[k]] = 0; mi[eri[k]] = 0; md[eri[k]] = 0;
      end
      mh = (mh + nr) % D;
      if (!st) begin
        for (int k = 0; k < AW; k++) begin
          if (a_v[k]) begin
            mv[mt] = 1; mr[mt] = a_rdy[k]; mi[mt] = 0; md[mt] = 0;
            mc[mt] = int'(a_cls[k*3 +: 3]);
            mt = (mt + 1) % D;
          end
        end
        mo = mo + na;
      end
      mo = mo - nr;
    end
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    for (int c = 0; c < NC; c++) evp[c] = ev[c];
    erp = RW'((1 << nr) - 1);
    chk(issue_valid === evp, "R3 issue strobes", int'(issue_valid), int'(evp));
    for (int c = 0; c < NC; c++)
      if (ev[c]) chk(int'(issue_idx[c*IW +: IW]) == ei[c], "R4 issue slot",
                     int'(issue_idx[c*IW +: IW]), ei[c]);
    chk(retire_valid === erp, "R8 retire strobes", int'(retire_valid), int'(erp));
    for (int k = 0; k < nr; k++)
      chk(int'(retire_idx[k*IW +: IW]) == eri[k], "R2 retire slot",
          int'(retire_idx[k*IW +: IW]), eri[k]);
  endtask

  task automatic rand_cycle(int pa, int pr, int pc, int pf);
    for (int k = 0; k < AW; k++) begin
      if (($urandom % 100) < pa) put(k, int'($urandom % NC), (($urandom % 100) < pr));
    end
    w_v = (($urandom % 2) == 0);
    w_idx = IW'($urandom % D);
    for (int p = 0; p < NC; p++) begin
      int s;
      s = int'($urandom % D);
      if ((mi[s] && !md[s] && ($urandom % 100) < pc) || ($urandom % 100) < 3) begin
        c_v[p] = 1'b1;
        c_idx[p*IW +: IW] = IW'(s);
      end
    end
    fl = (($urandom % 1000) < pf);
    tick();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    idle_inputs();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // reset state (R10)
    chk(issue_valid === '0 && retire_valid === '0, "R10 reset outputs",
        int'(issue_valid), 0);
    chk(stall === 1'b0, "R10 reset stall", int'(stall), 0);

    // A: latency of issue and single issue
    put(0, 0, 1); tick();
    chk(issue_valid === '0, "R5 no issue on alloc edge", int'(issue_valid), 0);
    tick();
    chk(issue_valid[0] === 1'b1 && issue_idx[4:0] == 0, "R5 issue next edge",
        int'(issue_valid), 1);
    tick();
    chk(issue_valid[0] === 1'b0, "R6 no second issue", int'(issue_valid), 0);

    // B: completion to retire latency
    c_v[0] = 1'b1; c_idx[4:0] = 5'd0; tick();
    chk(retire_valid === '0, "R9 not yet retired", int'(retire_valid), 0);
    tick();
    chk(retire_valid === 4'b0001 && retire_idx[4:0] == 0, "R9 retired",
        int'(retire_valid), 1);

    // C: four classes in one group issue together (slots 1..4)
    put(0, 0, 1); put(1, 1, 1); put(2, 4, 1); put(3, 5, 1); tick(); tick();
    chk(issue_valid === 6'b110011, "R3 parallel ports", int'(issue_valid), 51);
    chk(issue_idx[20 +: 5] == 5'd3, "R3 fp slot", int'(issue_idx[20 +: 5]), 3);

    // D: sparse lanes compact to slots 5,6; oldest first
    put(0, 0, 1); put(2, 0, 1); tick(); tick();
    chk(issue_valid[0] && issue_idx[4:0] == 5'd5, "R4 oldest load", int'(issue_idx[4:0]), 5);
    tick();
    chk(issue_valid[0] && issue_idx[4:0] == 5'd6, "R2 compacted lane", int'(issue_idx[4:0]), 6);

    // E: wake gating (slot 7)
    put(0, 2, 0); tick(); tick();
    chk(issue_valid[2] === 1'b0, "R7 held until wake", int'(issue_valid[2]), 0);
    w_v = 1; w_idx = 5'd7; tick(); tick();
    chk(issue_valid[2] && issue_idx[10 +: 5] == 5'd7, "R7 issued after wake",
        int'(issue_idx[10 +: 5]), 7);

    // F: flush with simultaneous allocation
    fl = 1; put(0, 0, 1); tick();
    chk(issue_valid === '0 && retire_valid === '0, "R10 flush outputs", int'(issue_valid), 0);
    put(0, 3, 1); tick(); tick();
    chk(issue_valid[3] && issue_idx[15 +: 5] == 5'd0, "R10 pointers reset",
        int'(issue_idx[15 +: 5]), 0);

    // random phases against the queue model
    repeat (1500) rand_cycle(70, 50, 30, 2);
    repeat (1500) rand_cycle(95, 15, 10, 0);
    repeat (1500) rand_cycle(30, 90, 80, 5);
    repeat (1500) rand_cycle(60, 60, 60, 1);
    report();
  end

endmodule